// File: doc/BRIEF.md
# Carry-Save Array Signed Multiplier

This block multiplies two W-bit two's complement numbers and returns their full 2W-bit two's complement product. It is purely combinational: there is no clock, no register and no handshake, so the product follows the operands within the same cycle. A surrounding pipeline registers the operands and the product wherever its timing budget calls for it. Because the block is a single combinational function, the port list carries plain data only and has no valid/ready pair. Nothing at this edge can stall, so there are no back-pressure rules to state.

Inside, every bit of the multiplier picks either zero or a copy of the multiplicand that is sign-extended to 2W bits and shifted left by the bit's position. These partial products are folded into a sum vector and a carry vector by a linear chain of 3:2 carry-save levels. The first level takes three partial products, and every later level takes the two vectors of the level before it plus one new partial product. The multiplier's sign bit carries a negative weight, so its partial product is bit-inverted and the missing +1 enters as the carry-in of the final adder. That adder is built from carry-lookahead groups, with the carry rippling from one group to the next, and it resolves the two vectors into the product. The width W must be at least 3.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of operands, `product_o` equals the two's complement product of `multiplicand_i` and `multiplier_i`, taken as signed W-bit values and given as a signed 2W-bit value.
- R2: For a multiplier bit i below W-1 that is 0, partial product i is zero. When only bit i (i < W-1) of the multiplier is set, the product is the multiplicand times 2^i.
- R3: The chain has W-2 carry-save levels. Each level's sum vector plus its carry vector equals the sum of that level's three inputs, modulo 2^(2W). As a result, the product is right for arbitrary operand patterns.
- R4: Multiplier bit W-1 weighs -2^(W-1). When the multiplier is exactly the most negative value, the product is -(multiplicand x 2^(W-1)). When that bit is 0, its inverted partial product is all ones.
- R5: The final adder returns sum vector + carry vector + 1, modulo 2^(2W), where the +1 is the completion of the sign-bit subtraction.
- R6: The most negative value times itself gives +2^(2W-2) with no overflow.
- R7: A zero on either operand gives a zero product.
- R8: A multiplier of -1 (all ones) gives the negated multiplicand in 2W bits. A most negative multiplicand then gives +2^(W-1).
- R9: The product depends only on the present operands. Changing them changes the product within the same cycle, and there is no state left over from earlier operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| multiplicand_i | input | W | Signed multiplicand |
| multiplier_i | input | W | Signed multiplier; each bit selects one partial product |
| product_o | output | 2W | Signed full-width product |

## Verification
The assertions are evaluated whenever the operands change. They check that each partial product below the sign bit is zero when its multiplier bit is clear, that the sign-bit partial product is all ones when that bit is clear, and that every carry-save level conserves the sum of its inputs. They also check that the final adder adds its two vectors and the carry-in, that the product equals the signed product, and that the most negative square comes out positive. Only the bench's scenarios show the specific corner results at the ports: single-bit multipliers, multiplication by -1 and by zero, operand changes applied back to back with no memory between them, and the spread of random operands.

// File: rtl/csm_pkg.sv
package csm_pkg;
  localparam int unsigned CSM_W_DEF   = 8;
  localparam int unsigned CSM_GRP_DEF = 4;

  function automatic int unsigned csm_groups(input int unsigned width, input int unsigned grp);
    return (width + grp - 1) / grp;
  endfunction
endpackage

// File: rtl/csm_ppgen.sv
module csm_ppgen #(
  parameter int unsigned W  = 8,
  parameter int unsigned PW = 2 * W
) (
  input  logic [W-1:0]          mcand,
  input  logic [W-1:0]          mplier,
  output logic [W-1:0][PW-1:0]  pp
);
  logic [PW-1:0] ext;
  assign ext = {{(PW-W){mcand[W-1]}}, mcand};

  for (genvar i = 0; i < W; i++) begin : g_pp
    if (i < W - 1) begin : g_pos
      assign pp[i] = mplier[i] ? (ext << i) : '0;
    end else begin : g_neg
      // negative weight: inverted here, +1 supplied as final carry-in
      assign pp[i] = ~(mplier[i] ? (ext << i) : '0);
    end
  end

  always_comb begin
    for (int i = 0; i < W - 1; i++) begin
      if (!mplier[i]) begin
        p_pp_zero_r2: assert (pp[i] == '0)
          else $error("R2: partial product %0d not zero", i);
      end
    end
    if (!mplier[W-1]) begin
      p_sign_pp_ones_r4: assert (pp[W-1] == '1)
        else $error("R4: idle sign partial product not all ones");
    end
  end
endmodule

// File: rtl/csm_csa.sv
module csm_csa #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] z,
  output logic [PW-1:0] s,
  output logic [PW-1:0] c
);
  logic [PW-1:0] maj;

  assign s   = x ^ y ^ z;
  assign maj = (x & y) | (x & z) | (y & z);
  assign c   = {maj[PW-2:0], 1'b0};

  always_comb begin
    p_csa_keep_r3: assert (PW'(s + c) == PW'(x + y + z))
      else $error("R3: carry-save level lost value");
  end
endmodule

// File: rtl/csm_cpa.sv
module csm_cpa #(
  parameter int unsigned PW  = 16,
  parameter int unsigned GRP = 4
) (
  input  logic [PW-1:0] a,
  input  logic [PW-1:0] b,
  input  logic          cin,
  output logic [PW-1:0] sum
);
  localparam int unsigned NG = csm_pkg::csm_groups(PW, GRP);

  logic [NG:0] gc;
  assign gc[0] = cin;

  for (genvar grp = 0; grp < NG; grp++) begin : g_grp
    localparam int unsigned LO = grp * GRP;
    localparam int unsigned HI = (LO + GRP > PW) ? PW : LO + GRP;
    localparam int unsigned BW = HI - LO;

    logic [BW-1:0] g, p;
    logic [BW:0]   c;

    assign g = a[HI-1:LO] & b[HI-1:LO];
    assign p = a[HI-1:LO] ^ b[HI-1:LO];

    // lookahead: each carry formed directly from g, p and the group carry-in
    always_comb begin
      logic pr;
      c    = '0;
      c[0] = gc[grp];
      for (int k = 0; k < int'(BW); k++) begin
        c[k+1] = g[k];
        pr = p[k];
        for (int j = k - 1; j >= 0; j--) begin
          c[k+1] = c[k+1] | (pr & g[j]);
          pr = pr & p[j];
        end
        c[k+1] = c[k+1] | (pr & gc[grp]);
      end
    end

    assign sum[HI-1:LO] = p ^ c[BW-1:0];
    assign gc[grp+1]    = c[BW];
  end

  always_comb begin
    p_cpa_add_r5: assert (sum == PW'(a + b + PW'(cin)))
      else $error("R5: final adder result wrong");
  end
endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
  parameter int unsigned W   = csm_pkg::CSM_W_DEF,
  parameter int unsigned GRP = csm_pkg::CSM_GRP_DEF
) (
  input  logic [W-1:0]   multiplicand_i,
  input  logic [W-1:0]   multiplier_i,
  output logic [2*W-1:0] product_o
);
  localparam int unsigned PW   = 2 * W;
  localparam int unsigned NLVL = W - 2;

  if (W < 3) begin : g_bad_width
    $error("csa_array_mult needs W >= 3");
  end

  logic [W-1:0][PW-1:0]    pp;
  logic [NLVL-1:0][PW-1:0] lvl_s;
  logic [NLVL-1:0][PW-1:0] lvl_c;

  csm_ppgen #(.W(W), .PW(PW)) u_pp (
    .mcand  (multiplicand_i),
    .mplier (multiplier_i),
    .pp     (pp)
  );

  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    if (k == 0) begin : g_first
      csm_csa #(.PW(PW)) u_csa (
        .x (pp[0]), .y (pp[1]), .z (pp[2]),
        .s (lvl_s[k]), .c (lvl_c[k])
      );
    end else begin : g_next
      csm_csa #(.PW(PW)) u_csa (
        .x (lvl_s[k-1]), .y (lvl_c[k-1]), .z (pp[k+2]),
        .s (lvl_s[k]), .c (lvl_c[k])
      );
    end
  end

  csm_cpa #(.PW(PW), .GRP(GRP)) u_cpa (
    .a   (lvl_s[NLVL-1]),
    .b   (lvl_c[NLVL-1]),
    .cin (1'b1),
    .sum (product_o)
  );

  always_comb begin
    p_product_r1: assert ($signed(product_o) == $signed(multiplicand_i) * $signed(multiplier_i))
      else $error("R1: product mismatch");
    if (multiplicand_i == {1'b1, {(W-1){1'b0}}} && multiplier_i == {1'b1, {(W-1){1'b0}}}) begin
      p_minmin_r6: assert (product_o == (PW'(1) << (PW - 2)))
        else $error("R6: most negative square wrong");
    end
  end
endmodule

// File: tb/sim_csa_array_mult.sv
module sim_csa_array_mult;
  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]  mc, mp;
  logic [PW-1:0] prod;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  csa_array_mult #(.W(N), .GRP(4)) u0 (
    .multiplicand_i (mc),
    .multiplier_i   (mp),
    .product_o      (prod)
  );

  function automatic logic [PW-1:0] golden(input logic [N-1:0] a, input logic [N-1:0] b);
    logic signed [PW-1:0] ea, eb;
    ea = PW'($signed(a));
    eb = PW'($signed(b));
    return PW'(ea * eb);
  endfunction

  task automatic apply_check(input string tag, input logic [N-1:0] a, input logic [N-1:0] b,
                             input logic [PW-1:0] exp);
    @(negedge clk);
    mc = a;
    mp = b;
    #2;
    checks++;
    if (prod !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a, b, prod, exp);
    end
  endtask

  task automatic t_idle_zero();
    checks++;
    if (prod !== '0) begin
      errors++;
      $display("FAIL R7 idle actual=%h expected=%h", prod, {PW{1'b0}});
    end
    apply_check("R7", 8'h00, 8'h5a, '0);
    apply_check("R7", 8'h80, 8'h00, '0);
    apply_check("R7", 8'h00, 8'h00, '0);
  endtask

  task automatic t_single_bits();
    for (int i = 0; i < N - 1; i++) begin
      apply_check("R2", 8'h35, 8'(1 << i), PW'(16'h0035 << i));
      apply_check("R2", 8'hcb, 8'(1 << i), PW'(16'hffcb << i));
    end
    apply_check("R4", 8'h01, 8'h80, 16'hff80);
    apply_check("R4", 8'h03, 8'h80, 16'hfe80);
    apply_check("R4", 8'hff, 8'h80, 16'h0080);
  endtask

  task automatic t_extremes();
    apply_check("R6", 8'h80, 8'h80, 16'h4000);
    apply_check("R1", 8'h7f, 8'h7f, 16'h3f01);
    apply_check("R1", 8'h7f, 8'h80, 16'hc080);
    apply_check("R8", 8'h80, 8'hff, 16'h0080);
    apply_check("R8", 8'h7f, 8'hff, 16'hff81);
    apply_check("R8", 8'h01, 8'hff, 16'hffff);
  endtask

  task automatic t_back_to_back();
    apply_check("R9", 8'h12, 8'h34, golden(8'h12, 8'h34));
    apply_check("R9", 8'hf0, 8'h0f, golden(8'hf0, 8'h0f));
    apply_check("R9", 8'h12, 8'h34, golden(8'h12, 8'h34));
  endtask

  task automatic t_random();
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] a, b;
      a = N'($urandom);
      b = N'($urandom);
      apply_check("R1 R3 R5", a, b, golden(a, b));
    end
  endtask

  initial begin
    mc = '0;
    mp = '0;
    #1;
    t_idle_zero();
    t_single_bits();
    t_extremes();
    t_back_to_back();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule